// File: doc/BRIEF.md
# Double-Error BCH Syndrome and Error-Weight Classifier

This block sits at the head of a decoder for a shortened binary BCH code that corrects up to two bit errors. The code has 256 data bits and 18 check bits, which makes a 274-bit word over GF(2^9). The whole received word arrives in parallel. Fixed XOR trees reduce it to the two odd syndromes, S1 and S3. The even syndromes are not computed, because for a binary code each one is the square of an odd syndrome.

From the two syndromes the block forms the cubic discriminant R = S1^3 + S3. Together with S1 and S3, R sorts the word into one of four classes: clean, one error, two errors, or uncorrectable. A locator search placed downstream can then choose the cheap single-error path or the full two-error path before it starts. The field polynomial and the bit ordering of the incoming word are parameters.

A word is taken in on a cycle where the valid strobe is high. The syndromes, the discriminant and the class appear registered on the following cycle. They hold there until the next strobe.

Top module: `bch_weight_classifier`

## Requirements
- R1: While reset is asserted and after its release with no strobe yet, `res_valid` is 0 and `syn1`, `syn3`, `disc` and `err_class` are all zero.
- R2: `syn1` equals the GF(2^9) sum of alpha^(238+j) over every set bit j of `rx_word`. The field is generated by x^9 + x^4 + 1, and bit i of a field value is the coefficient of alpha^i.
- R3: `syn3` equals the GF(2^9) sum of alpha^(3*(238+j) mod 511) over every set bit j of `rx_word`.
- R4: `disc` equals syn1*syn1*syn1 + syn3, computed with multiplication in the same field.
- R5: When syn1 = 0 and syn3 = 0, `err_class` is 2'b00 (clean). The all-zero word is clean.
- R6: When syn1 != 0 and disc = 0, `err_class` is 2'b01 (single). Any word with exactly one set bit, at any of the 274 positions, is classed single.
- R7: When syn1 != 0 and disc != 0, `err_class` is 2'b10 (double). Any word with exactly two set bits is classed double.
- R8: When syn1 = 0 and syn3 != 0, `err_class` is 2'b11 (uncorrectable). A three-bit pattern whose positions sum to zero in the field lands here.
- R9: A word presented with `in_valid` high at a rising edge has its results on the outputs, with `res_valid` high, right after that edge. `res_valid` is low after an edge where `in_valid` was low. While `in_valid` is low, a change on `rx_word` leaves all result outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Capture strobe for `rx_word` |
| rx_word | input | 274 | Received code word, bit j at field position alpha^(238+j) |
| res_valid | output | 1 | High for the cycle after a capture |
| syn1 | output | 9 | First odd syndrome S1 |
| syn3 | output | 9 | Third syndrome S3 |
| disc | output | 9 | Discriminant S1^3 + S3 |
| err_class | output | 2 | 00 clean, 01 single, 10 double, 11 uncorrectable |

## Verification
The bench sweeps a single error across every one of the 274 positions. A tree column built with the wrong exponent offset, or wrong at the top position where the exponent wraps to alpha^0, would give a wrong S1 or S3 at exactly that position. A faulty cube would make some single errors show a nonzero discriminant and be classed double.

Double errors at the two ends of the word check that R never vanishes for two distinct positions. A three-bit pattern found by search drives S1 to zero with S3 nonzero. A classifier that looked only at S1 would call that pattern clean. The bench also changes the word while the strobe is low; a missing clock enable would show up there as moving outputs.

// File: rtl/bch_cls_pkg.sv
package bch_cls_pkg;

  typedef enum logic [1:0] {
    CLS_CLEAN  = 2'b00,
    CLS_SINGLE = 2'b01,
    CLS_DOUBLE = 2'b10,
    CLS_UNCORR = 2'b11
  } err_class_t;

endpackage

// File: rtl/bch_gf_mult.sv
module bch_gf_mult #(
  parameter int          M    = 9,
  parameter logic [M:0]  POLY = 10'h211
) (
  input  logic [M-1:0] a,
  input  logic [M-1:0] b,
  output logic [M-1:0] p
);

  localparam logic [M-1:0] RED = POLY[M-1:0];

  function automatic logic [M-1:0] xtime(input logic [M-1:0] v);
    return {v[M-2:0], 1'b0} ^ (v[M-1] ? RED : '0);
  endfunction

  always_comb begin
    logic [M-1:0] acc;
    acc = '0;
    for (int i = M - 1; i >= 0; i--) begin
      acc = xtime(acc) ^ (b[i] ? a : '0);
    end
    p = acc;
  end

  always_comb begin
    if (a == '0 || b == '0) begin
      assert_zero_absorb_R4: assert (p == '0)
        else $error("product with a zero operand is nonzero");
    end
  end

endmodule

// File: rtl/bch_syn_tree.sv
module bch_syn_tree #(
  parameter int          M         = 9,
  parameter int          N         = 274,
  parameter logic [M:0]  POLY      = 10'h211,
  parameter int          POWER     = 1,
  parameter bit          MSB_FIRST = 1'b0
) (
  input  logic [N-1:0] word,
  output logic [M-1:0] syn
);

  localparam int ORDER = (1 << M) - 1;
  localparam int FIRST = ORDER + 1 - N;
  localparam logic [M-1:0] RED = POLY[M-1:0];

  function automatic logic [M-1:0] alpha_pow(input int e);
    logic [M-1:0] v;
    v = {{(M-1){1'b0}}, 1'b1};
    for (int i = 0; i < e; i++) begin
      v = {v[M-2:0], 1'b0} ^ (v[M-1] ? RED : '0);
    end
    return v;
  endfunction

  logic [M-1:0] terms [N];

  for (genvar j = 0; j < N; j++) begin : g_col
    localparam int POS = MSB_FIRST ? (N - 1 - j) : j;
    localparam int EXP = ((FIRST + POS) * POWER) % ORDER;
    localparam logic [M-1:0] COL = alpha_pow(EXP);
    assign terms[j] = word[j] ? COL : '0;
  end

  always_comb begin
    logic [M-1:0] acc;
    acc = '0;
    for (int j = 0; j < N; j++) begin
      acc = acc ^ terms[j];
    end
    syn = acc;
  end

endmodule

// File: rtl/bch_weight_decide.sv
module bch_weight_decide
  import bch_cls_pkg::*;
#(
  parameter int M = 9
) (
  input  logic [M-1:0] s1,
  input  logic [M-1:0] s3,
  input  logic [M-1:0] r,
  output err_class_t   cls
);

  logic s1_zero, s3_zero, r_zero;

  assign s1_zero = (s1 == '0);
  assign s3_zero = (s3 == '0);
  assign r_zero  = (r == '0);

  always_comb begin
    if (s1_zero) begin
      cls = s3_zero ? CLS_CLEAN : CLS_UNCORR;
    end else begin
      cls = r_zero ? CLS_SINGLE : CLS_DOUBLE;
    end
  end

endmodule

// File: rtl/bch_weight_classifier.sv
module bch_weight_classifier
  import bch_cls_pkg::*;
#(
  parameter int          M         = 9,
  parameter int          N         = 274,
  parameter logic [M:0]  POLY      = 10'h211,
  parameter bit          MSB_FIRST = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [N-1:0] rx_word,
  output logic         res_valid,
  output logic [M-1:0] syn1,
  output logic [M-1:0] syn3,
  output logic [M-1:0] disc,
  output logic [1:0]   err_class
);

  logic [M-1:0] s1_c, s3_c, s1_sq, s1_cube, r_c;
  err_class_t   cls_c;

  bch_syn_tree #(.M(M), .N(N), .POLY(POLY), .POWER(1), .MSB_FIRST(MSB_FIRST))
    u_tree1 (.word(rx_word), .syn(s1_c));

  bch_syn_tree #(.M(M), .N(N), .POLY(POLY), .POWER(3), .MSB_FIRST(MSB_FIRST))
    u_tree3 (.word(rx_word), .syn(s3_c));

  bch_gf_mult #(.M(M), .POLY(POLY)) u_sq   (.a(s1_c),  .b(s1_c), .p(s1_sq));
  bch_gf_mult #(.M(M), .POLY(POLY)) u_cube (.a(s1_sq), .b(s1_c), .p(s1_cube));

  assign r_c = s1_cube ^ s3_c;

  bch_weight_decide #(.M(M)) u_decide (.s1(s1_c), .s3(s3_c), .r(r_c), .cls(cls_c));

  logic         vld_q, vld_n;
  logic [M-1:0] s1_q, s3_q, r_q, s1_n, s3_n, r_n;
  err_class_t   cls_q, cls_n;

  always_comb begin
    vld_n = in_valid;
    s1_n  = s1_q;
    s3_n  = s3_q;
    r_n   = r_q;
    cls_n = cls_q;
    if (in_valid) begin
      s1_n  = s1_c;
      s3_n  = s3_c;
      r_n   = r_c;
      cls_n = cls_c;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      s1_q  <= '0;
      s3_q  <= '0;
      r_q   <= '0;
      cls_q <= CLS_CLEAN;
    end else begin
      vld_q <= vld_n;
      s1_q  <= s1_n;
      s3_q  <= s3_n;
      r_q   <= r_n;
      cls_q <= cls_n;
    end
  end

  assign res_valid = vld_q;
  assign syn1      = s1_q;
  assign syn3      = s3_q;
  assign disc      = r_q;
  assign err_class = cls_q;

  assert_capture_R9: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> res_valid)
    else $error("strobe not followed by valid result");

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!res_valid && $stable(syn1) && $stable(syn3) && $stable(disc)))
    else $error("results moved without a strobe");

  assert_clean_shape_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (err_class == CLS_CLEAN) |-> (syn1 == '0 && syn3 == '0))
    else $error("clean class with nonzero syndrome");

  assert_single_shape_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (err_class == CLS_SINGLE) |-> (syn1 != '0 && disc == '0))
    else $error("single class inconsistent with syndromes");

  assert_double_shape_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (err_class == CLS_DOUBLE) |-> (syn1 != '0 && disc != '0))
    else $error("double class inconsistent with syndromes");

  assert_uncorr_shape_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (err_class == CLS_UNCORR) |-> (syn1 == '0 && syn3 != '0))
    else $error("uncorrectable class inconsistent with syndromes");

endmodule

// File: tb/bch_weight_classifier_tb.sv
module bch_weight_classifier_tb;

  localparam int M     = 9;
  localparam int N     = 274;
  localparam int ORD   = 511;
  localparam int FIRST = 238;
  localparam int NV    = 8;
  localparam int VEC [NV][4] = '{
    '{ -1,  -1, -1, 0},
    '{  0,  -1, -1, 1},
    '{273,  -1, -1, 1},
    '{ 17,  -1, -1, 1},
    '{  0,   1, -1, 2},
    '{  0, 273, -1, 2},
    '{ 18, 255, -1, 2},
    '{100, 101, -1, 2}
  };

  logic         clk = 1'b0;
  logic         rst_n;
  logic         in_valid;
  logic [N-1:0] rx_word;
  logic         res_valid;
  logic [M-1:0] syn1, syn3, disc;
  logic [1:0]   err_class;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  int alog [ORD];
  int lg   [512];

  always #4 clk = ~clk;

  bch_weight_classifier u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .rx_word(rx_word),
    .res_valid(res_valid), .syn1(syn1), .syn3(syn3), .disc(disc),
    .err_class(err_class)
  );

  function automatic int fmul(input int a, input int b);
    if (a == 0 || b == 0) return 0;
    return alog[(lg[a] + lg[b]) % ORD];
  endfunction

  function automatic int pos_val(input int p, input int pw);
    return alog[((FIRST + p) * pw) % ORD];
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic apply_and_check(input int p0, input int p1, input int p2, input int ecls);
    logic [N-1:0] w;
    int es1, es3, er;
    w = '0; es1 = 0; es3 = 0;
    if (p0 >= 0) begin w[p0] = 1'b1; es1 ^= pos_val(p0, 1); es3 ^= pos_val(p0, 3); end
    if (p1 >= 0) begin w[p1] = 1'b1; es1 ^= pos_val(p1, 1); es3 ^= pos_val(p1, 3); end
    if (p2 >= 0) begin w[p2] = 1'b1; es1 ^= pos_val(p2, 1); es3 ^= pos_val(p2, 3); end
    er = fmul(fmul(es1, es1), es1) ^ es3;
    @(negedge clk);
    rx_word  = w;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check(res_valid == 1'b1, "R9 valid after strobe", int'(res_valid), 1);
    check(int'(syn1) == es1, "R2 syn1", int'(syn1), es1);
    check(int'(syn3) == es3, "R3 syn3", int'(syn3), es3);
    check(int'(disc) == er,  "R4 disc", int'(disc), er);
    case (ecls)
      0: check(int'(err_class) == 0, "R5 clean class", int'(err_class), 0);
      1: check(int'(err_class) == 1, "R6 single class", int'(err_class), 1);
      2: check(int'(err_class) == 2, "R7 double class", int'(err_class), 2);
      default: check(int'(err_class) == 3, "R8 uncorrectable class", int'(err_class), 3);
    endcase
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    int x;
    bit found;
    int fa, fb, fc;
    logic [M-1:0] h1, h3, hr;
    logic [1:0]   hc;

    x = 1;
    for (int i = 0; i < ORD; i++) begin
      alog[i] = x;
      lg[x] = i;
      x = x << 1;
      if (x & 512) x = x ^ 'h211;
    end
    lg[0] = 0;

    rst_n = 1'b0; in_valid = 1'b0; rx_word = '0;
    #1;
    check(res_valid == 1'b0 && syn1 == '0 && syn3 == '0 && disc == '0 && err_class == 2'b00,
          "R1 outputs during reset", int'(syn1), 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(res_valid == 1'b0 && err_class == 2'b00 && syn1 == '0,
          "R1 after release", int'(res_valid), 0);

    for (int v = 0; v < NV; v++) begin
      apply_and_check(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3]);
    end

    // R6: single error at each position
    for (int p = 0; p < N; p++) begin
      apply_and_check(p, -1, -1, 1);
    end

    // R8: search three positions whose field values sum to zero
    found = 1'b0; fa = 0; fb = 0; fc = 0;
    for (int a = 0; a < N && !found; a++) begin
      for (int b = a + 1; b < N && !found; b++) begin
        int e, c;
        e = lg[pos_val(a, 1) ^ pos_val(b, 1)];
        c = (e - FIRST + ORD) % ORD;
        if (c < N && c != a && c != b) begin
          found = 1'b1; fa = a; fb = b; fc = c;
        end
      end
    end
    check(found, "R8 pattern exists", int'(found), 1);
    if (found) apply_and_check(fa, fb, fc, 3);

    // R9: hold while strobe low
    apply_and_check(5, 200, -1, 2);
    h1 = syn1; h3 = syn3; hr = disc; hc = err_class;
    @(negedge clk);
    rx_word = '1;
    @(negedge clk);
    rx_word = {N{1'b0}} | 1;
    @(negedge clk);
    check(res_valid == 1'b0, "R9 valid drops", int'(res_valid), 0);
    check(syn1 == h1 && syn3 == h3, "R9 syndromes held", int'(syn1), int'(h1));
    check(disc == hr && err_class == hc, "R9 class held", int'(err_class), int'(hc));

    // R1: reset in mid-run clears results
    apply_and_check(7, -1, -1, 1);
    rst_n = 1'b0;
    #1;
    check(syn1 == '0 && disc == '0 && err_class == 2'b00 && res_valid == 1'b0,
          "R1 mid-run reset", int'(syn1), 0);
    @(negedge clk);
    rst_n = 1'b1;
    apply_and_check(-1, -1, -1, 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule